// File: doc/BRIEF.md
# Lane Test-Mode Entry Controller

This block extends a serial-link lane start-up machine with two black-box test modes that external test equipment can select purely through the line, with no software access to the unit. The block watches decoded received words, each tagged as control or data. From the Started state, it counts unbroken runs of two dedicated test control words. A full run of the first word puts the lane into a receive loopback test, in which the transmit path sends back the received data after it has crossed the clock domain. A full run of the second word puts the lane into a transmit test, in which the transmit path sends a PRBS-31 pattern from a built-in generator.

Either test state is left when the normal first initialisation control word arrives, or on synchronous reset. The normal link states after Started, the line codec, the serialiser and the elastic buffer lie outside the block. They appear only as the `start_req` input, the `norm_word` and `lb_word` inputs, and the transmit select output.

Top module: `lane_test_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to the idle state after that edge. In the idle state `in_started`, `in_rx_test` and `in_tx_test` are low and `tx_sel` is 0. Both run counters are cleared, so any state they held before the reset has no effect afterwards.
- R2: In the idle state, `start_req` high at a clock edge sets `in_started` after that edge.
- R3: A control word has `rx_valid`=1 and `rx_ctrl`=1, and its `rx_word` equals `CW_INIT1`, `CW_TINIT1` or `CW_TINIT2`. A data word (`rx_ctrl`=0) that carries the same value is not a control word.
- R4: In Started, `RUN_LEN` consecutive TINIT1 control words (default 1023) enter the receive loopback test at the edge of the last word. From then on `in_rx_test` is 1, `tx_sel` is 1 and `tx_word` equals `lb_word`.
- R5: In Started, `RUN_LEN` consecutive TINIT2 control words enter the transmit test at the edge of the last word. From then on `in_tx_test` is 1 and `tx_sel` is 2.
- R6: In Started, any valid word that does not continue the current run clears the run, and the lane stays in Started. This includes data, other control words and the other test word. Cycles with `rx_valid` low neither count nor clear.
- R7: Test words received outside the Started state are not counted.
- R8: An INIT1 control word in either test state returns the lane to Started after that edge. `tx_sel` then reads 0 and `tx_word` equals `norm_word`. The run counters start again from zero.
- R9: In a test state, every word other than INIT1 is ignored, and the lane stays in that test state.
- R10: When the transmit test is entered, the 31-bit generator register is loaded with `SEED`. For each bit, the output bit is register bit 30 XOR bit 27 (x^31 + x^28 + 1), and the register then shifts left with that bit entering at bit 0. `W` bits are produced per clock, and the first bit goes to `tx_word[W-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Normal start-up sequence has reached Started |
| rx_valid | input | 1 | A decoded received word is present |
| rx_ctrl | input | 1 | Received word is a control word |
| rx_word | input | W | Decoded received word |
| norm_word | input | W | Word from the normal transmit path |
| lb_word | input | W | Received data after the clock-domain crossing |
| in_started | output | 1 | Lane is in Started |
| in_rx_test | output | 1 | Lane is in the receive loopback test |
| in_tx_test | output | 1 | Lane is in the transmit PRBS test |
| tx_sel | output | 2 | Transmit source: 0 normal, 1 loopback, 2 PRBS |
| tx_word | output | W | Word sent to the transmit encoder |

## Verification
Every state change takes effect one clock after the word that causes it. The lane enters a test state at the edge of the last run word, returns to Started at the edge of the INIT1 word, and enters Started at the edge that samples `start_req`. The bench drives each word on a falling edge and samples on the following falling edge, so every check sees exactly one rising edge of effect. The first PRBS word is valid in the same sampling window as the entry. Each later window holds the next word of the pattern, which the bench compares with its own bit-serial model of the polynomial.

// File: rtl/lane_test_ctrl.sv
module lane_test_ctrl #(
  parameter int          W         = 32,
  parameter int          RUN_LEN   = 1023,
  parameter logic [30:0] SEED      = 31'h1234_5678,
  parameter logic [W-1:0] CW_INIT1  = 32'hBC01_0101,
  parameter logic [W-1:0] CW_TINIT1 = 32'hBC0A_0A0A,
  parameter logic [W-1:0] CW_TINIT2 = 32'hBC0B_0B0B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_req,
  input  logic         rx_valid,
  input  logic         rx_ctrl,
  input  logic [W-1:0] rx_word,
  input  logic [W-1:0] norm_word,
  input  logic [W-1:0] lb_word,
  output logic         in_started,
  output logic         in_rx_test,
  output logic         in_tx_test,
  output logic [1:0]   tx_sel,
  output logic [W-1:0] tx_word
);
  localparam int CNTW = $clog2(RUN_LEN + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(RUN_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_STARTED, S_RXT, S_TXT} st_t;

  st_t             st;
  logic [CNTW-1:0] run1, run2;
  logic [30:0]     lfsr, lfsr_nxt, pr_s;
  logic [W-1:0]    pr_word;

  wire is_ctl = rx_valid && rx_ctrl;
  wire is_i1  = is_ctl && (rx_word == CW_INIT1);
  wire is_t1  = is_ctl && (rx_word == CW_TINIT1);
  wire is_t2  = is_ctl && (rx_word == CW_TINIT2);

  always_comb begin
    pr_s = lfsr;
    pr_word = '0;
    for (int i = 0; i < W; i++) begin
      pr_word[W-1-i] = pr_s[30] ^ pr_s[27];
      pr_s = {pr_s[29:0], pr_s[30] ^ pr_s[27]};
    end
    lfsr_nxt = pr_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      run1 <= '0;
      run2 <= '0;
      lfsr <= SEED;
    end else begin
      case (st)
        S_IDLE: if (start_req) st <= S_STARTED;
        S_STARTED: if (rx_valid) begin
          if (is_t1) begin
            run2 <= '0;
            if (run1 == LAST) begin
              run1 <= '0;
              st   <= S_RXT;
            end else run1 <= run1 + 1'b1;
          end else if (is_t2) begin
            run1 <= '0;
            if (run2 == LAST) begin
              run2 <= '0;
              lfsr <= SEED;
              st   <= S_TXT;
            end else run2 <= run2 + 1'b1;
          end else begin
            run1 <= '0;
            run2 <= '0;
          end
        end
        S_RXT: if (is_i1) st <= S_STARTED;
        S_TXT: begin
          lfsr <= lfsr_nxt;
          if (is_i1) st <= S_STARTED;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_started = (st == S_STARTED);
  assign in_rx_test = (st == S_RXT);
  assign in_tx_test = (st == S_TXT);
  assign tx_sel     = in_tx_test ? 2'd2 : in_rx_test ? 2'd1 : 2'd0;
  assign tx_word    = in_tx_test ? pr_word : in_rx_test ? lb_word : norm_word;
endmodule

// File: rtl/lane_test_ctrl_chk.sv
module lane_test_ctrl_chk #(
  parameter int           W         = 32,
  parameter int           RUN_LEN   = 1023,
  parameter logic [W-1:0] CW_INIT1  = 32'hBC01_0101,
  parameter logic [W-1:0] CW_TINIT1 = 32'hBC0A_0A0A,
  parameter logic [W-1:0] CW_TINIT2 = 32'hBC0B_0B0B
) (
  input logic         clk,
  input logic         rst,
  input logic         start_req,
  input logic         rx_valid,
  input logic         rx_ctrl,
  input logic [W-1:0] rx_word,
  input logic         in_started,
  input logic         in_rx_test,
  input logic         in_tx_test,
  input logic [1:0]   tx_sel,
  input logic [W-1:0] tx_word
);
  localparam int CNTW = $clog2(RUN_LEN + 2);
  logic [CNTW-1:0] c1, c2;
  wire idle = !in_started && !in_rx_test && !in_tx_test;
  wire w1 = rx_valid && rx_ctrl && rx_word == CW_TINIT1;
  wire w2 = rx_valid && rx_ctrl && rx_word == CW_TINIT2;
  wire wi = rx_valid && rx_ctrl && rx_word == CW_INIT1;

  always_ff @(posedge clk) begin
    if (rst || !in_started) begin
      c1 <= '0;
      c2 <= '0;
    end else if (rx_valid) begin
      c1 <= w1 ? c1 + 1'b1 : '0;
      c2 <= w2 ? c2 + 1'b1 : '0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> idle && tx_sel == 2'd0);
  // R1
  state_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_started, in_rx_test, in_tx_test}));
  // R2
  start_enter_chk: assert property (@(posedge clk) disable iff (rst)
    idle && start_req |=> in_started);
  // R4
  rx_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_rx_test) |-> c1 == CNTW'(RUN_LEN) && $past(in_started));
  // R5
  tx_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_tx_test) |-> c2 == CNTW'(RUN_LEN) && $past(in_started));
  // R8
  init1_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_rx_test || in_tx_test) && wi |=> in_started && tx_sel == 2'd0);
  // R9
  test_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_tx_test && !wi |=> in_tx_test);
  // R10
  prbs_rec_chk: assert property (@(posedge clk) disable iff (rst)
    in_tx_test && $past(in_tx_test) |-> tx_word[W-1] == ($past(tx_word[30]) ^ $past(tx_word[27])));
endmodule

bind lane_test_ctrl lane_test_ctrl_chk #(
  .W(W), .RUN_LEN(RUN_LEN), .CW_INIT1(CW_INIT1), .CW_TINIT1(CW_TINIT1), .CW_TINIT2(CW_TINIT2)
) u_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl),
  .rx_word(rx_word), .in_started(in_started), .in_rx_test(in_rx_test),
  .in_tx_test(in_tx_test), .tx_sel(tx_sel), .tx_word(tx_word)
);

// File: tb/sim_lane_test_ctrl.sv
module sim_lane_test_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int RUN = 1023;
  localparam logic [30:0] SEED = 31'h1234_5678;
  localparam logic [W-1:0] I1 = 32'hBC01_0101;
  localparam logic [W-1:0] T1 = 32'hBC0A_0A0A;
  localparam logic [W-1:0] T2 = 32'hBC0B_0B0B;
  localparam logic [W-1:0] NW = 32'hA5A5_0F0F;
  localparam logic [W-1:0] LW = 32'h5A5A_F0F0;

  logic clk = 0, rst = 1, start_req = 0, rx_valid = 0, rx_ctrl = 0;
  logic [W-1:0] rx_word = '0;
  logic in_started, in_rx_test, in_tx_test;
  logic [1:0] tx_sel;
  logic [W-1:0] tx_word;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_test_ctrl u0 (
    .clk(clk), .rst(rst), .start_req(start_req), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl),
    .rx_word(rx_word), .norm_word(NW), .lb_word(LW), .in_started(in_started),
    .in_rx_test(in_rx_test), .in_tx_test(in_tx_test), .tx_sel(tx_sel), .tx_word(tx_word)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic state_is(input string req, input logic s, input logic r, input logic t, input logic [1:0] sel);
    check(req, {28'd0, in_started, in_rx_test, in_tx_test, 1'b0} | {30'd0, tx_sel} << 0 ? {28'd0, in_started, in_rx_test, in_tx_test, 1'b0} : 32'd0, {28'd0, s, r, t, 1'b0});
    check(req, {30'd0, tx_sel}, {30'd0, sel});
  endtask

  task automatic word(input logic [W-1:0] w, input logic c, input logic v);
    rx_word = w; rx_ctrl = c; rx_valid = v;
    @(negedge clk);
    rx_valid = 0; rx_ctrl = 0; rx_word = '0;
  endtask

  task automatic run(input logic [W-1:0] w, input int n);
    for (int i = 0; i < n; i++) word(w, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    rst = 1; @(negedge clk); rst = 0;
  endtask

  task automatic do_start();
    start_req = 1; @(negedge clk); start_req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    state_is("R1 reset state", 0, 0, 0, 2'd0);
    check("R1 normal word", tx_word, NW);
  endtask

  task automatic t_start();
    do_reset(); do_start();
    state_is("R2 start", 1, 0, 0, 2'd0);
  endtask

  task automatic t_rx_entry();
    do_reset(); do_start();
    run(T1, RUN - 1);
    state_is("R4 not yet", 1, 0, 0, 2'd0);
    run(T1, 1);
    state_is("R4 rx entry", 0, 1, 0, 2'd1);
    check("R4 loopback word", tx_word, LW);
    word(T2, 1, 1); word(32'h1234, 0, 1);
    state_is("R9 rx ignores", 0, 1, 0, 2'd1);
    word(I1, 1, 1);
    state_is("R8 rx exit", 1, 0, 0, 2'd0);
    check("R8 normal word", tx_word, NW);
  endtask

  task automatic t_tx_entry();
    logic [30:0] m = SEED;
    logic [W-1:0] e;
    do_reset(); do_start();
    run(T2, RUN);
    state_is("R5 tx entry", 0, 0, 1, 2'd2);
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < W; i++) begin
        e[W-1-i] = m[30] ^ m[27];
        m = {m[29:0], m[30] ^ m[27]};
      end
      check("R10 prbs word", tx_word, e);
      if (k == 1) word(T1, 1, 1); else @(negedge clk);
    end
    state_is("R9 tx ignores", 0, 0, 1, 2'd2);
    word(I1, 1, 1);
    state_is("R8 tx exit", 1, 0, 0, 2'd0);
    run(T2, RUN - 1);
    state_is("R8 counter restarted", 1, 0, 0, 2'd0);
    run(T2, 1);
    state_is("R5 re-entry", 0, 0, 1, 2'd2);
  endtask

  task automatic t_break();
    do_reset(); do_start();
    run(T1, RUN - 1); word(T2, 1, 1); run(T1, 1);
    state_is("R6 broken by other test word", 1, 0, 0, 2'd0);
    run(T2, RUN - 1); word(I1, 1, 1); run(T2, 1);
    state_is("R6 broken by INIT1", 1, 0, 0, 2'd0);
    run(T1, 500); word(32'h0, 0, 0); word(32'h0, 0, 0); run(T1, RUN - 500);
    state_is("R6 gaps do not break", 0, 1, 0, 2'd1);
  endtask

  task automatic t_data_same_value();
    do_reset(); do_start();
    run(T1, RUN - 1); word(T1, 0, 1); run(T1, 1);
    state_is("R3 data word breaks run", 1, 0, 0, 2'd0);
    for (int i = 0; i < RUN; i++) word(T2, 0, 1);
    state_is("R3 data never counted", 1, 0, 0, 2'd0);
  endtask

  task automatic t_idle_ignore();
    do_reset();
    run(T1, RUN);
    state_is("R7 idle ignores", 0, 0, 0, 2'd0);
    do_start(); run(T1, 1);
    state_is("R7 no carry over", 1, 0, 0, 2'd0);
  endtask

  task automatic t_reset_mid();
    do_reset(); do_start();
    run(T2, RUN - 1);
    do_reset(); do_start(); run(T2, 1);
    state_is("R1 counters cleared", 1, 0, 0, 2'd0);
    run(T2, RUN);
    do_reset();
    state_is("R1 reset from test", 0, 0, 0, 2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_start();
    t_rx_entry();
    t_tx_entry();
    t_break();
    t_data_same_value();
    t_idle_ignore();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule